// File: doc/BRIEF.md
# Two-Wire Slave Address Matcher

This block sits on the slave side of a two-wire serial bus (clock line and data line, both sampled in the local clock domain). After every START or repeated START it assembles the address byte from the data line, taking one bit on each rising edge of the serial clock. It then decides whether this slave has been addressed. The matching rules are a primary 7-bit address, the general call, and a second register. That register acts either as an extra 7-bit address or as a don't-care mask over the primary address. The block also handles 10-bit addressing (header byte plus low byte), and it has a mode in which every address byte goes to software for the decision.

The result is a one-cycle match strobe, a code that names the rule that fired, the R/W bit, and the received byte. Software uses the byte in the software-decision mode. The data phase, acknowledge driving and clock stretching belong to neighbouring logic.

Top module: `twi_addr_matcher`

## Requirements
- R1: After reset `match_o` is 0 and `rule_o` is 0 (none). No strobe appears until a full address byte has been received after a START.
- R2: A first byte whose upper seven bits equal `cfg_own_addr` gives exactly one strobe with `rule_o`=1 (primary). `rw_o` is equal to bit 0 of the byte, and `addr_byte_o` holds the byte.
- R3: With `cfg_gcall_en`=1, the byte 0x00 gives a strobe with `rule_o`=3 (general call) and `rw_o`=0. With `cfg_gcall_en`=0, 0x00 is handled only by the address rules.
- R4: With `cfg_alt_is_mask`=0, a first byte whose upper seven bits equal `cfg_alt_addr` gives a strobe with `rule_o`=2 (second address).
- R5: With `cfg_alt_is_mask`=1, every set bit of `cfg_alt_addr` is ignored when the byte is compared with `cfg_own_addr`. A match reports `rule_o`=1, and `rule_o`=2 never occurs.
- R6: Priority runs from general call, to primary (exact or masked), to second address. When several rules hold, only the highest is reported.
- R7: With `cfg_sw_decide`=1, every first byte gives a strobe with `rule_o`=5 (software) whatever its value. If 10-bit mode is on and the byte starts with 11110, the following byte gives a second strobe with `rule_o`=5.
- R8: With `cfg_ten_en`=1, a first byte of 11110, then `cfg_ten_addr[9:8]`, then R/W, followed by a second byte equal to `cfg_ten_addr[7:0]`, gives one strobe after the second byte. That strobe has `rule_o`=4 and `rw_o` taken from the first byte. A header alone, a wrong header or a wrong low byte gives no strobe, and 11110xxx bytes never match 7-bit rules.
- R9: A START or repeated START discards partly received bits and restarts assembly. After a STOP, clock edges without a new START are ignored.
- R10: The strobe is high in the cycle that follows SYNC_STAGES+2 clock edges after the serial clock input rises for the last bit of the deciding byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| cfg_own_addr | input | 7 | Primary 7-bit slave address |
| cfg_alt_addr | input | 7 | Second address or don't-care mask |
| cfg_alt_is_mask | input | 1 | 1: second register is a mask; 0: second address |
| cfg_gcall_en | input | 1 | Enable general call recognition |
| cfg_sw_decide | input | 1 | Pass every address byte to software |
| cfg_ten_en | input | 1 | Enable 10-bit addressing |
| cfg_ten_addr | input | 10 | 10-bit slave address |
| match_o | output | 1 | One-cycle match strobe |
| rule_o | output | 3 | Rule code: 0 none, 1 primary, 2 second, 3 general call, 4 ten-bit, 5 software |
| rw_o | output | 1 | R/W bit of the addressed transfer |
| addr_byte_o | output | 8 | Last received address byte |

## Verification
The decision register can publish the strobe for a completed byte on the same clock edge at which a repeated START clears the shift register. The bench provokes this by pulling the data line low while the serial clock is still high, one cycle after the rising edge for the eighth bit. That timing makes the START detection land on the decision edge. The bench then expects two strobes: the first for the interrupted byte with its R/W of 1, the second for the byte sent after the repeated START. Separate sweeps cover all 256 first-byte values under three configurations, comparing against a rule model computed in the bench.

// File: rtl/twi_am_pkg.sv
package twi_am_pkg;
  localparam int BYTE_W = 8;
  localparam int A7_W   = 7;
  localparam int A10_W  = 10;
  localparam int HDR_W  = 5;
  localparam logic [HDR_W-1:0] TEN_HDR = 5'b11110;

  typedef enum logic [2:0] {
    RULE_NONE  = 3'd0,
    RULE_PRI   = 3'd1,
    RULE_ALT   = 3'd2,
    RULE_GCALL = 3'd3,
    RULE_TEN   = 3'd4,
    RULE_SW    = 3'd5
  } rule_e;
endpackage

// File: rtl/twi_am_sync.sv
module twi_am_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
  assign sda_o      = sda_s;
endmodule

// File: rtl/twi_am_shift.sv
module twi_am_shift
  import twi_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              sda_i,
  output logic              rdy_o,
  output logic              second_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int LAST2 = 2 * BYTE_W;
  localparam int CNT_W = $clog2(LAST2 + 1);
  localparam logic [CNT_W-1:0] C_LAST1 = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] C_ACK1  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] C_LAST2 = CNT_W'(LAST2);

  logic              act_q, act_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sr_q, sr_n;
  logic              rdy_q, rdy_n;
  logic              sec_q, sec_n;

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    sr_n  = sr_q;
    rdy_n = 1'b0;
    sec_n = sec_q;
    if (start_i) begin
      act_n = 1'b1;
      cnt_n = '0;
    end else if (stop_i) begin
      act_n = 1'b0;
    end else if (scl_rise_i && act_q) begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_q != C_ACK1) sr_n = {sr_q[BYTE_W-2:0], sda_i};
      if (cnt_q == C_LAST1) begin
        rdy_n = 1'b1;
        sec_n = 1'b0;
      end
      if (cnt_q == C_LAST2) begin
        rdy_n = 1'b1;
        sec_n = 1'b1;
        act_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      sr_q  <= '0;
      rdy_q <= 1'b0;
      sec_q <= 1'b0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
      sr_q  <= sr_n;
      rdy_q <= rdy_n;
      sec_q <= sec_n;
    end
  end

  assign rdy_o    = rdy_q;
  assign second_o = sec_q;
  assign byte_o   = sr_q;

  // R2: a byte-ready pulse never lasts two cycles
  a_r2_rdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> !rdy_q);
  // R9: a START seen while idle leaves no byte pending next cycle
  a_r9_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !rdy_q);
endmodule

// File: rtl/twi_am_decide.sv
module twi_am_decide
  import twi_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdy_i,
  input  logic              second_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [A7_W-1:0]   own_i,
  input  logic [A7_W-1:0]   alt_i,
  input  logic              alt_mask_i,
  input  logic              gcall_en_i,
  input  logic              sw_i,
  input  logic              ten_en_i,
  input  logic [A10_W-1:0]  ten_addr_i,
  output logic              match_o,
  output rule_e             rule_o,
  output logic              rw_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic              hit_q, hit_n;
  rule_e             rule_q, rule_n;
  logic              rw_q, rw_n;
  logic [BYTE_W-1:0] byte_q, byte_n;
  logic              pend_q, pend_n;
  logic              rw10_q, rw10_n;

  logic [A7_W-1:0] rx7, ign;
  logic            is_hdr, pri_ok;

  assign rx7    = byte_i[BYTE_W-1:1];
  assign ign    = alt_mask_i ? alt_i : '0;
  assign is_hdr = byte_i[BYTE_W-1 -: HDR_W] == TEN_HDR;
  assign pri_ok = ((rx7 ^ own_i) & ~ign) == '0;

  always_comb begin
    hit_n  = 1'b0;
    rule_n = rule_q;
    rw_n   = rw_q;
    byte_n = byte_q;
    pend_n = pend_q;
    rw10_n = rw10_q;
    if (rdy_i) begin
      byte_n = byte_i;
      rule_n = RULE_NONE;
      if (!second_i) begin
        pend_n = 1'b0;
        rw10_n = byte_i[0];
        rw_n   = byte_i[0];
        if (sw_i) begin
          hit_n  = 1'b1;
          rule_n = RULE_SW;
          pend_n = ten_en_i & is_hdr;
        end else if (ten_en_i && is_hdr) begin
          pend_n = byte_i[2:1] == ten_addr_i[A10_W-1:BYTE_W];
        end else if (gcall_en_i && byte_i == '0) begin
          hit_n  = 1'b1;
          rule_n = RULE_GCALL;
        end else if (pri_ok) begin
          hit_n  = 1'b1;
          rule_n = RULE_PRI;
        end else if (!alt_mask_i && rx7 == alt_i) begin
          hit_n  = 1'b1;
          rule_n = RULE_ALT;
        end
      end else begin
        pend_n = 1'b0;
        rw_n   = rw10_q;
        if (pend_q && sw_i) begin
          hit_n  = 1'b1;
          rule_n = RULE_SW;
        end else if (pend_q && byte_i == ten_addr_i[BYTE_W-1:0]) begin
          hit_n  = 1'b1;
          rule_n = RULE_TEN;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      rule_q <= RULE_NONE;
      rw_q   <= 1'b0;
      byte_q <= '0;
      pend_q <= 1'b0;
      rw10_q <= 1'b0;
    end else begin
      hit_q  <= hit_n;
      rule_q <= rule_n;
      rw_q   <= rw_n;
      byte_q <= byte_n;
      pend_q <= pend_n;
      rw10_q <= rw10_n;
    end
  end

  assign match_o = hit_q;
  assign rule_o  = rule_q;
  assign rw_o    = rw_q;
  assign byte_o  = byte_q;

  // R10: a strobe is always one cycle behind a completed byte
  a_r10_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(rdy_i));
  // R1: a strobe always names a rule
  a_r1_rule_named: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> rule_q != RULE_NONE);
  // R8: a ten-bit hit comes only from a second byte
  a_r8_ten_second: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && rule_q == RULE_TEN) |-> $past(second_i));
  // R3: a general call is always the zero byte with write direction
  a_r3_gcall_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && rule_q == RULE_GCALL) |-> (byte_q == '0 && !rw_q));
endmodule

// File: rtl/twi_addr_matcher.sv
module twi_addr_matcher
  import twi_am_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [6:0]        cfg_own_addr,
  input  logic [6:0]        cfg_alt_addr,
  input  logic              cfg_alt_is_mask,
  input  logic              cfg_gcall_en,
  input  logic              cfg_sw_decide,
  input  logic              cfg_ten_en,
  input  logic [9:0]        cfg_ten_addr,
  output logic              match_o,
  output logic [2:0]        rule_o,
  output logic              rw_o,
  output logic [7:0]        addr_byte_o
);
  logic scl_rise, start_det, stop_det, sda_s;
  logic rdy, second;
  logic [BYTE_W-1:0] rx_byte;
  rule_e rule;

  twi_am_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .start_o(start_det), .stop_o(stop_det), .sda_o(sda_s)
  );

  twi_am_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start_i(start_det), .stop_i(stop_det),
    .scl_rise_i(scl_rise), .sda_i(sda_s),
    .rdy_o(rdy), .second_o(second), .byte_o(rx_byte)
  );

  twi_am_decide u_decide (
    .clk(clk), .rst_n(rst_n), .rdy_i(rdy), .second_i(second), .byte_i(rx_byte),
    .own_i(cfg_own_addr), .alt_i(cfg_alt_addr), .alt_mask_i(cfg_alt_is_mask),
    .gcall_en_i(cfg_gcall_en), .sw_i(cfg_sw_decide), .ten_en_i(cfg_ten_en),
    .ten_addr_i(cfg_ten_addr),
    .match_o(match_o), .rule_o(rule), .rw_o(rw_o), .byte_o(addr_byte_o)
  );

  assign rule_o = rule;

  // R5: in mask mode the second-address rule is never reported
  a_r5_no_alt_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && cfg_alt_is_mask && $stable(cfg_alt_is_mask)) |-> rule_o != 3'd2);
endmodule

// File: tb/twi_addr_matcher_tb.sv
module twi_addr_matcher_tb;
  logic clk, rst_n, scl, sda;
  logic [6:0] own, alt;
  logic amask, gc, sw, ten;
  logic [9:0] ten_addr;
  logic match;
  logic [2:0] rule;
  logic rw;
  logic [7:0] abyte;

  int n_tests, n_fail, cyc, rise8, n_str, str_cyc;
  logic [2:0] last_rule, first_rule;
  logic last_rw, first_rw;
  logic [7:0] last_byte;
  bit done;

  twi_addr_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .cfg_own_addr(own), .cfg_alt_addr(alt), .cfg_alt_is_mask(amask),
    .cfg_gcall_en(gc), .cfg_sw_decide(sw), .cfg_ten_en(ten), .cfg_ten_addr(ten_addr),
    .match_o(match), .rule_o(rule), .rw_o(rw), .addr_byte_o(abyte)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && match) begin
      if (n_str == 0) begin
        first_rule = rule;
        first_rw   = rw;
      end
      n_str     = n_str + 1;
      last_rule = rule;
      last_rw   = rw;
      last_byte = abyte;
      str_cyc   = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda = 1'b1; w(2); scl = 1'b1; w(4); sda = 1'b0; w(4); scl = 1'b0; w(2);
  endtask

  task automatic do_stop();
    sda = 1'b0; w(2); scl = 1'b1; w(4); sda = 1'b1; w(4);
  endtask

  task automatic send_bit(input logic b, input bit mark);
    sda = b; w(2); scl = 1'b1;
    if (mark) rise8 = cyc;
    w(4); scl = 1'b0; w(2);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i], i == 0);
    send_bit(1'b1, 1'b0);
  endtask

  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input bit two);
    n_str = 0;
    do_start();
    send_byte(b0);
    if (two) send_byte(b1);
    do_stop();
    w(4);
  endtask

  function automatic logic [3:0] mdl(input logic [7:0] b);
    logic [6:0] m;
    m = amask ? alt : 7'd0;
    if (sw) return {1'b1, 3'd5};
    if (ten && b[7:3] == 5'b11110) return 4'd0;
    if (gc && b == 8'h00) return {1'b1, 3'd3};
    if (((b[7:1] ^ own) & ~m) == 7'd0) return {1'b1, 3'd1};
    if (!amask && b[7:1] == alt) return {1'b1, 3'd2};
    return 4'd0;
  endfunction

  task automatic sweep(input string req);
    for (int v = 0; v < 256; v++) begin
      logic [3:0] e;
      e = mdl(8'(v));
      xfer(8'(v), 8'h00, 1'b0);
      chk(n_str == int'(e[3]), {req, " strobe count"}, n_str, int'(e[3]));
      if (e[3] && n_str == 1) begin
        chk(last_rule == e[2:0], {req, " rule"}, last_rule, e[2:0]);
        chk(last_rw == v[0], {req, " rw (R2)"}, last_rw, v[0]);
        chk(last_byte == 8'(v), {req, " byte"}, last_byte, v);
      end
    end
  endtask

  initial begin
    n_tests = 0; n_fail = 0; cyc = 0; n_str = 0; done = 0;
    scl = 1'b1; sda = 1'b1; rst_n = 1'b0;
    own = 7'h2A; alt = 7'h55; amask = 1'b0; gc = 1'b1; sw = 1'b0;
    ten = 1'b1; ten_addr = 10'h2C5;
    w(3);
    chk(match == 1'b0, "R1 reset strobe", match, 0);
    chk(rule == 3'd0, "R1 reset rule", rule, 0);
    rst_n = 1'b1;
    w(3);
    chk(n_str == 0, "R1 no strobe after reset", n_str, 0);

    // R2 primary plus R10 latency
    xfer(8'h55, 8'h00, 1'b0);
    chk(n_str == 1 && last_rule == 3'd1 && last_rw == 1'b1, "R2 primary read", last_rule, 1);
    xfer(8'h54, 8'h00, 1'b0);
    chk(str_cyc - rise8 == 4, "R10 latency", str_cyc - rise8, 4);

    // R2 R3 R4 R6 sweep: address mode, general call on, ten-bit on
    sweep("R2/R3/R4/R6/R8 sweep A");

    // R5 sweep: mask mode, general call off, ten-bit off
    amask = 1'b1; alt = 7'h05; gc = 1'b0; ten = 1'b0;
    sweep("R5/R3 sweep B");

    // R7 sweep: software mode
    sw = 1'b1; ten = 1'b1;
    sweep("R7 sweep C");

    // R7 ten-bit header in software mode gives two strobes
    xfer(8'hF4, 8'h33, 1'b1);
    chk(n_str == 2 && last_rule == 3'd5 && last_byte == 8'h33, "R7 sw ten-bit second byte", n_str, 2);
    sw = 1'b0;

    // R8 ten-bit cases
    xfer(8'hF4, 8'hC5, 1'b1);
    chk(n_str == 1 && last_rule == 3'd4 && last_rw == 1'b0, "R8 ten-bit write", last_rule, 4);
    xfer(8'hF5, 8'hC5, 1'b1);
    chk(n_str == 1 && last_rule == 3'd4 && last_rw == 1'b1, "R8 ten-bit read rw", last_rw, 1);
    chk(str_cyc - rise8 == 4, "R10 ten-bit latency", str_cyc - rise8, 4);
    xfer(8'hF4, 8'hC4, 1'b1);
    chk(n_str == 0, "R8 wrong low byte", n_str, 0);
    xfer(8'hF6, 8'hC5, 1'b1);
    chk(n_str == 0, "R8 wrong header bits", n_str, 0);
    ten = 1'b0; own = 7'h7A;
    xfer(8'hF4, 8'h00, 1'b0);
    chk(n_str == 1 && last_rule == 3'd1, "R8 ten-bit off gives 7-bit match", last_rule, 1);

    // R6 priority: general call over primary 0, primary over equal second
    own = 7'h00; gc = 1'b1; amask = 1'b0; alt = 7'h00;
    xfer(8'h00, 8'h00, 1'b0);
    chk(n_str == 1 && last_rule == 3'd3, "R6 gcall over primary", last_rule, 3);
    own = 7'h2A; alt = 7'h2A;
    xfer(8'h54, 8'h00, 1'b0);
    chk(n_str == 1 && last_rule == 3'd1, "R6 primary over second", last_rule, 1);
    alt = 7'h55;

    // R9 partial bits discarded by repeated START
    n_str = 0;
    do_start();
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    do_start();
    send_byte(8'h54);
    do_stop(); w(4);
    chk(n_str == 1 && last_rule == 3'd1 && last_byte == 8'h54, "R9 restart discards bits", n_str, 1);

    // R9 clocking after STOP without START is ignored
    n_str = 0;
    scl = 1'b0; w(2);
    for (int i = 7; i >= 0; i--) send_bit(own[i > 0 ? i - 1 : 0], 1'b0);
    sda = 1'b1; w(2); scl = 1'b1; w(6);
    chk(n_str == 0, "R9 no START ignored", n_str, 0);

    // R9/R2 repeated START on the same edge as the strobe
    n_str = 0;
    do_start();
    for (int i = 7; i >= 1; i--) send_bit(8'h55 >> i, 1'b0);
    sda = 1'b1; w(2); scl = 1'b1; w(1); sda = 1'b0; w(4); scl = 1'b0; w(2);
    send_byte(8'h54);
    do_stop(); w(4);
    chk(n_str == 2, "R9 strobe count at restart edge", n_str, 2);
    chk(first_rule == 3'd1 && first_rw == 1'b1, "R2 first strobe kept at restart", first_rw, 1);
    chk(last_rule == 3'd1 && last_rw == 1'b0, "R9 byte after tight restart", last_rw, 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule